// File: doc/BRIEF.md
# UART Receive Character Buffer

This block sits between a UART deserializer and the CPU-side receive data register. It holds up to two received characters in a first-in, first-out buffer. Each stored character keeps its own frame-error and parity-error bits. The head character is always presented with its status, so a reader sees the errors that belong to the character it is about to take.

When both slots are full, one more finished character is held in the shift-register stage. It moves into the buffer as soon as a read frees a slot. If another start bit arrives while the buffer is full and that held character is still waiting, an overrun is flagged against the current head. Any further character that completes during that time is lost. Every read strobe takes the head character. Clearing the receiver enable empties everything.

Top module: `uart_rx_fifo`

## Requirements
- R1: After reset `rxc`, `irq`, `head_dor`, `head_fe`, `head_pe` and `head_data` are all 0.
- R2: `rxc` is 1 exactly when at least one unread character is stored. Characters leave in arrival order, and a read strobe with data present removes the head character in the same clock edge.
- R3: `head_fe` is 1 when the head character arrived with `stop_bit` = 0, and 0 when it arrived with `stop_bit` = 1.
- R4: `head_pe` is 1 only when the head character arrived with `par_bad` = 1 while `par_chk_en` was 1 on that same cycle.
- R5: A character that completes while both slots are full is held. It becomes the tail on the same edge as the read that frees a slot.
- R6: `head_dor` becomes 1 on the edge after `start_det` if, at that moment, both slots are full, a character is held and no read is made. It stays 1 until the next read, which clears it. A character that completes while one is already held is discarded.
- R7: While `rx_en` is 0 the buffer, the held character and the overrun flag are cleared, so `rxc` is 0 after the next edge. Completed characters are ignored during that time.
- R8: A read strobe while the buffer is empty has no effect.
- R9: A read and a newly completed character on the same edge lose nothing and duplicate nothing, with either one or two characters stored.
- R10: `irq` is 1 exactly when `rxc` and `rxie` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_en | input | 1 | Receiver enable; 0 flushes the buffer |
| par_chk_en | input | 1 | Parity checking enable |
| rxie | input | 1 | Receive interrupt enable |
| char_done | input | 1 | One-cycle strobe: a character finished deserializing |
| char_data | input | DW | Received character |
| stop_bit | input | 1 | Sampled first stop bit of that character |
| par_bad | input | 1 | Parity check result of that character (1 = mismatch) |
| start_det | input | 1 | One-cycle strobe: a new start bit was detected |
| rd | input | 1 | Read strobe from the data register port |
| head_data | output | DW | Head character (0 when empty) |
| head_fe | output | 1 | Frame error of the head character |
| head_pe | output | 1 | Parity error of the head character |
| head_dor | output | 1 | Overrun flag, attached to the head character |
| rxc | output | 1 | Receive complete: unread data present |
| irq | output | 1 | Receive interrupt request |

## Verification
The bench builds the block with DW = 8, its default. The data patterns it uses set both the most and the least significant bit. With the depth fixed at two plus one held stage, a few back-to-back characters are enough to fill every stage. That brings the held-character path, the overrun window and the lost character within reach. Simultaneous push and pop is driven both with one character stored and with two.

// File: rtl/uart_rx_fifo.sv
module uart_rx_fifo #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_en,
  input  logic          par_chk_en,
  input  logic          rxie,
  input  logic          char_done,
  input  logic [DW-1:0] char_data,
  input  logic          stop_bit,
  input  logic          par_bad,
  input  logic          start_det,
  input  logic          rd,
  output logic [DW-1:0] head_data,
  output logic          head_fe,
  output logic          head_pe,
  output logic          head_dor,
  output logic          rxc,
  output logic          irq
);
  localparam int EW = DW + 2;

  logic [EW-1:0] slot0, slot1, held, new_ent, src;
  logic [1:0]    cnt;
  logic          held_v, ovr;
  logic          full, pop, src_v, push;

  assign full    = (cnt == 2'd2);
  assign pop     = rd && (cnt != 2'd0);
  assign new_ent = {par_chk_en & par_bad, ~stop_bit, char_data};
  assign src     = held_v ? held : new_ent;
  assign src_v   = held_v || char_done;
  assign push    = src_v && (!full || pop);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0 <= '0; slot1 <= '0; held <= '0;
      cnt <= 2'd0; held_v <= 1'b0; ovr <= 1'b0;
    end else if (!rx_en) begin
      slot0 <= '0; slot1 <= '0; held <= '0;
      cnt <= 2'd0; held_v <= 1'b0; ovr <= 1'b0;
    end else begin
      case ({push, pop})
        2'b10: begin
          if (cnt == 2'd0) slot0 <= src;
          else             slot1 <= src;
          cnt <= cnt + 2'd1;
        end
        2'b01: begin
          slot0 <= slot1;
          slot1 <= '0;
          cnt   <= cnt - 2'd1;
        end
        2'b11: begin
          if (cnt == 2'd1) slot0 <= src;
          else begin
            slot0 <= slot1;
            slot1 <= src;
          end
        end
        default: ;
      endcase

      if (held_v) begin
        if (push) begin
          held_v <= char_done;
          held   <= new_ent;
        end
      end else if (char_done && !push) begin
        held_v <= 1'b1;
        held   <= new_ent;
      end

      if (pop)                              ovr <= 1'b0;
      else if (start_det && full && held_v) ovr <= 1'b1;
    end
  end

  assign rxc       = (cnt != 2'd0);
  assign head_data = rxc ? slot0[DW-1:0] : '0;
  assign head_fe   = rxc & slot0[DW];
  assign head_pe   = rxc & slot0[DW+1];
  assign head_dor  = ovr;
  assign irq       = rxc & rxie;

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt != 2'd3);

  // R5
  held_only_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    held_v |-> full);

  // R6
  dor_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(head_dor) |-> $past(start_det && full && held_v));

  // R6
  dor_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && rx_en) |=> !head_dor);

  // R7
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rxc && !head_dor));

  // R9
  swap_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop && rx_en) |=> $stable(cnt));

  // R10
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (rxc && rxie));
endmodule

// File: tb/tb_uart_rx_fifo.sv
`timescale 1ns/1ps
module tb_uart_rx_fifo;
  localparam int DW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_en = 1'b0, par_chk_en = 1'b0, rxie = 1'b0;
  logic char_done = 1'b0, stop_bit = 1'b1, par_bad = 1'b0, start_det = 1'b0, rd = 1'b0;
  logic [DW-1:0] char_data = '0;
  logic [DW-1:0] head_data;
  logic head_fe, head_pe, head_dor, rxc, irq;

  int checks = 0, fails = 0;
  logic [DW+1:0] expq[$];

  always #2.5 clk = ~clk;

  uart_rx_fifo #(.DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en), .par_chk_en(par_chk_en), .rxie(rxie),
    .char_done(char_done), .char_data(char_data), .stop_bit(stop_bit), .par_bad(par_bad),
    .start_det(start_det), .rd(rd), .head_data(head_data), .head_fe(head_fe),
    .head_pe(head_pe), .head_dor(head_dor), .rxc(rxc), .irq(irq)
  );

  task automatic check(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // driver: one character; push expectation only if it should be kept
  task automatic send(input logic [DW-1:0] d, input logic sb, input logic pb, input logic keep);
    char_done = 1'b1; char_data = d; stop_bit = sb; par_bad = pb;
    if (keep) expq.push_back({par_chk_en & pb, ~sb, d});
    @(negedge clk);
    char_done = 1'b0; stop_bit = 1'b1; par_bad = 1'b0;
  endtask

  // monitor: compare head against scoreboard, then read it
  task automatic take(input string req);
    logic [DW+1:0] e;
    e = expq.pop_front();
    check({head_pe, head_fe, head_data} == e && rxc, req, {rxc, head_pe, head_fe, head_data}, {1'b1, e});
    rd = 1'b1;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic swap(input logic [DW-1:0] d, input string req);
    logic [DW+1:0] e;
    e = expq.pop_front();
    check({head_pe, head_fe, head_data} == e, req, {head_pe, head_fe, head_data}, e);
    expq.push_back({1'b0, 1'b0, d});
    char_done = 1'b1; char_data = d; stop_bit = 1'b1; par_bad = 1'b0; rd = 1'b1;
    @(negedge clk);
    char_done = 1'b0; rd = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    fails++; checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    // R1
    check(!rxc && !irq && !head_dor && !head_fe && !head_pe && head_data == 0, "R1",
          {rxc, irq, head_dor, head_fe, head_pe, head_data}, 0);
    rst_n = 1'b1; rx_en = 1'b1;
    @(negedge clk);

    // R10 and R2
    rxie = 1'b1;
    send(8'hA5, 1'b1, 1'b0, 1'b1);
    check(rxc == 1'b1, "R2", rxc, 1);
    check(irq == 1'b1, "R10", irq, 1);
    rxie = 1'b0; #1;
    check(irq == 1'b0, "R10", irq, 0);

    // R3 frame error per entry
    send(8'h81, 1'b0, 1'b0, 1'b1);
    take("R3");
    take("R3");
    check(!rxc, "R2", rxc, 0);

    // R4 parity gated by enable at arrival
    par_chk_en = 1'b0;
    send(8'h3C, 1'b1, 1'b1, 1'b1);
    par_chk_en = 1'b1;
    send(8'hC3, 1'b1, 1'b1, 1'b1);
    par_chk_en = 1'b0;
    take("R4");
    take("R4");

    // R8 read on empty
    rd = 1'b1; @(negedge clk); rd = 1'b0;
    check(!rxc && head_data == 0, "R8", {rxc, head_data}, 0);
    send(8'h5A, 1'b1, 1'b0, 1'b1);
    take("R8");

    // R5 held third character
    send(8'h11, 1'b1, 1'b0, 1'b1);
    send(8'h22, 1'b1, 1'b0, 1'b1);
    send(8'h33, 1'b0, 1'b0, 1'b1);
    check(rxc && !head_dor, "R5", {rxc, head_dor}, 2'b10);
    take("R5");
    take("R5");
    take("R5");
    check(!rxc, "R5", rxc, 0);

    // R6 overrun
    send(8'h44, 1'b1, 1'b0, 1'b1);
    send(8'h55, 1'b1, 1'b0, 1'b1);
    send(8'h66, 1'b1, 1'b0, 1'b1);
    start_det = 1'b1; @(negedge clk); start_det = 1'b0;
    check(head_dor == 1'b1, "R6", head_dor, 1);
    send(8'h77, 1'b1, 1'b0, 1'b0);
    check(head_dor == 1'b1, "R6", head_dor, 1);
    take("R6");
    check(head_dor == 1'b0, "R6", head_dor, 0);
    take("R6");
    take("R6");
    check(!rxc, "R6", rxc, 0);

    // R9 simultaneous push and pop
    send(8'h01, 1'b1, 1'b0, 1'b1);
    swap(8'h02, "R9");
    check(rxc && head_data == 8'h02, "R9", head_data, 8'h02);
    send(8'h03, 1'b1, 1'b0, 1'b1);
    swap(8'h04, "R9");
    take("R9");
    take("R9");
    check(!rxc, "R9", rxc, 0);

    // R7 flush and ignore while disabled
    send(8'h90, 1'b1, 1'b0, 1'b0);
    send(8'h91, 1'b1, 1'b0, 1'b0);
    rx_en = 1'b0; @(negedge clk);
    check(!rxc && !irq, "R7", rxc, 0);
    send(8'h92, 1'b1, 1'b0, 1'b0);
    check(!rxc, "R7", rxc, 0);
    rx_en = 1'b1; @(negedge clk);
    check(!rxc && head_data == 0, "R7", {rxc, head_data}, 0);
    send(8'h93, 1'b1, 1'b0, 1'b1);
    take("R7");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule